// File: doc/BRIEF.md
# Loop Branch Predictor

This block recognises conditional branches that behave like loop control: a run of outcomes in one direction closed by a single outcome in the other. For each such branch it learns the exact run length (the trip count) and the dominant direction. It then predicts the dominant direction on every iteration and flips its guess for the single exit outcome. Saturating counters always miss that exit; this block predicts it.

Storage is a small direct-mapped table. The low bits of the PC select a slot, and the remaining bits are kept as a tag. A slot holds the dominant direction, the learned trip count with a known flag, the running iteration count and a two-bit confidence. The predict port is combinational: it gives hit, direction and a confident flag for any PC and leaves the table unchanged. The update port writes the resolved outcome of one branch per clock. An external selector uses the confident flag to decide when to take this predictor's answer over another one.

Top module: `loop_pred`

## Requirements
- R1: After a synchronous active-high reset every slot is empty. Every predict lookup misses, with pred_hit, pred_taken and pred_confident all 0.
- R2: An update whose PC misses replaces the slot at index upd_pc[IDX_W-1:0]. The outcome becomes the dominant direction, the trip count becomes unknown, the iteration count becomes 1 and the confidence becomes 0. A following lookup of that PC hits, predicts that direction and is not confident.
- R3: While the trip count of a hit slot is unknown, the prediction is the dominant direction.
- R4: Once the trip count is known, the prediction is the opposite of the dominant direction when the iteration count equals the trip count. In every other case it is the dominant direction.
- R5: A hit update with the dominant direction increments the iteration count. An exit outcome (opposite direction, iteration count at least 1) sets the trip count to the iteration count, marks it known and clears the iteration count to 0.
- R6: On an exit, confidence rises by one (saturating at 3) if the trip count was known and equals the count just closed. Otherwise confidence is cleared to 0.
- R7: pred_confident is 1 only on a hit whose confidence is 3. A miss drives all three predict outputs to 0.
- R8: The dominant direction is held per slot, so loops with taken-dominant and not-taken-dominant branches are both learned. An outcome opposite to the dominant direction while the iteration count is 0 makes that outcome the new dominant direction. It also sets the iteration count to 1, the trip count to unknown and the confidence to 0.
- R9: A dominant-direction update on a slot whose iteration count is already 2^CNT_W-1 empties the slot, so the next lookup misses.
- R10: The tag is upd_pc[PC_W-1:IDX_W]. A PC with the same index and a different tag misses, and an update with that PC evicts the previous owner of the slot.
- R11: A lookup has no effect on state. With no update, repeated lookups of one PC return identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_pc | input | PC_W | PC of the branch being predicted |
| pred_hit | output | 1 | Slot holds this PC |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_confident | output | 1 | Confidence is at maximum |
| upd_valid | input | 1 | Resolved outcome present this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench builds the block with PC_W=12, IDX_W=3 and CNT_W=4, which gives eight slots and an iteration limit of 15. That limit lets a run of sixteen dominant outcomes reach the invalidation corner in a few cycles. The eight slots let random loop streams on four PCs collide with stray PCs on shared indices, which exercises tag eviction. Trip counts of 1 to 6 reach full confidence within a few loop passes, so confidence build-up, saturation and reset on a changed trip count all occur many times.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Kind of write applied to the addressed slot on an update
    typedef enum logic [2:0] {
        ACT_ALLOC,
        ACT_STEP,
        ACT_EXIT,
        ACT_FLIP,
        ACT_DROP
    } act_e;

    typedef logic [1:0] conf_t;

    localparam conf_t CONF_TOP = 2'd3;

    // Confidence after an exit: climb on a repeated trip count, else restart
    function automatic conf_t conf_next(input conf_t c, input logic same);
        if (!same)
            return '0;
        return (c == CONF_TOP) ? c : conf_t'(c + 2'd1);
    endfunction

endpackage

// File: rtl/lp_slot.sv
module lp_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/lp_predict.sv
module lp_predict #(
    parameter int CNT_W = 8
) (
    input  logic             hit,
    input  logic             dir,
    input  logic             trip_known,
    input  logic [CNT_W-1:0] trip,
    input  logic [CNT_W-1:0] iter,
    input  lp_pkg::conf_t    conf,
    output logic             taken,
    output logic             confident
);
    logic at_exit;

    always_comb begin
        at_exit   = trip_known && (iter == trip);
        taken     = hit && (at_exit ? ~dir : dir);
        confident = hit && (conf == lp_pkg::CONF_TOP);
    end
endmodule

// File: rtl/lp_learn.sv
module lp_learn #(
    parameter int TAG_W = 28,
    parameter int CNT_W = 8
) (
    input  logic             hit,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             outcome,
    input  logic             cur_dir,
    input  logic             cur_tk,
    input  logic [CNT_W-1:0] cur_trip,
    input  logic [CNT_W-1:0] cur_iter,
    input  lp_pkg::conf_t    cur_conf,
    output logic             n_valid,
    output logic [TAG_W-1:0] n_tag,
    output logic             n_dir,
    output logic             n_tk,
    output logic [CNT_W-1:0] n_trip,
    output logic [CNT_W-1:0] n_iter,
    output lp_pkg::conf_t    n_conf
);
    import lp_pkg::*;

    localparam logic [CNT_W-1:0] ITER_TOP = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    act_e act;
    logic same_trip;

    always_comb begin
        if (!hit)
            act = ACT_ALLOC;
        else if (outcome == cur_dir)
            act = (cur_iter == ITER_TOP) ? ACT_DROP : ACT_STEP;
        else if (cur_iter == '0)
            act = ACT_FLIP;
        else
            act = ACT_EXIT;
    end

    always_comb begin
        same_trip = cur_tk && (cur_trip == cur_iter);
        n_valid   = 1'b1;
        n_tag     = in_tag;
        n_dir     = cur_dir;
        n_tk      = cur_tk;
        n_trip    = cur_trip;
        n_iter    = cur_iter;
        n_conf    = cur_conf;
        case (act)
            ACT_ALLOC, ACT_FLIP: begin
                n_dir  = outcome;
                n_tk   = 1'b0;
                n_trip = '0;
                n_iter = ONE;
                n_conf = '0;
            end
            ACT_STEP: n_iter = cur_iter + ONE;
            ACT_EXIT: begin
                n_conf = conf_next(cur_conf, same_trip);
                n_trip = cur_iter;
                n_tk   = 1'b1;
                n_iter = '0;
            end
            default: begin
                n_valid = 1'b0;
                n_dir   = 1'b0;
                n_tk    = 1'b0;
                n_trip  = '0;
                n_iter  = '0;
                n_conf  = '0;
            end
        endcase
    end
endmodule

// File: rtl/loop_pred.sv
module loop_pred #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic            pred_confident,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    import lp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             dir;
        logic             tk;
        logic [CNT_W-1:0] trip;
        logic [CNT_W-1:0] iter;
        conf_t            conf;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    ent_t             tbl [DEPTH];
    ent_t             nxt;
    ent_t             rd_e;
    ent_t             up_e;
    logic [DEPTH-1:0] wr;
    logic [IDX_W-1:0] p_idx, u_idx;
    logic [TAG_W-1:0] p_tag, u_tag;
    logic             u_hit;

    assign p_idx = pred_pc[IDX_W-1:0];
    assign p_tag = pred_pc[PC_W-1:IDX_W];
    assign u_idx = upd_pc[IDX_W-1:0];
    assign u_tag = upd_pc[PC_W-1:IDX_W];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign wr[g] = upd_valid && (u_idx == IDX_W'(g));
        lp_slot #(.W(ENT_W)) u_slot (
            .clk (clk),
            .rst (rst),
            .we  (wr[g]),
            .d   (nxt),
            .q   (tbl[g])
        );
    end

    assign rd_e     = tbl[p_idx];
    assign up_e     = tbl[u_idx];
    assign pred_hit = rd_e.valid && (rd_e.tag == p_tag);
    assign u_hit    = up_e.valid && (up_e.tag == u_tag);

    lp_predict #(.CNT_W(CNT_W)) u_predict (
        .hit        (pred_hit),
        .dir        (rd_e.dir),
        .trip_known (rd_e.tk),
        .trip       (rd_e.trip),
        .iter       (rd_e.iter),
        .conf       (rd_e.conf),
        .taken      (pred_taken),
        .confident  (pred_confident)
    );

    lp_learn #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_learn (
        .hit      (u_hit),
        .in_tag   (u_tag),
        .outcome  (upd_taken),
        .cur_dir  (up_e.dir),
        .cur_tk   (up_e.tk),
        .cur_trip (up_e.trip),
        .cur_iter (up_e.iter),
        .cur_conf (up_e.conf),
        .n_valid  (nxt.valid),
        .n_tag    (nxt.tag),
        .n_dir    (nxt.dir),
        .n_tk     (nxt.tk),
        .n_trip   (nxt.trip),
        .n_iter   (nxt.iter),
        .n_conf   (nxt.conf)
    );
endmodule

// File: rtl/loop_pred_chk.sv
module loop_pred_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] pred_pc,
    input logic            pred_hit,
    input logic            pred_taken,
    input logic            pred_confident,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_hit); // R1

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (!pred_taken && !pred_confident)); // R7

    AST_ALLOC_UNSURE: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && (upd_pc == pred_pc) && !pred_hit) |=>
        ((pred_pc != $past(upd_pc)) || (pred_hit && !pred_confident))); // R2

    AST_LOOKUP_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!$past(upd_valid) && $stable(pred_pc)) |->
        ($stable(pred_hit) && $stable(pred_taken) && $stable(pred_confident))); // R11
endmodule

bind loop_pred loop_pred_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/loop_pred_bench.sv
`timescale 1ns/1ps
module loop_pred_bench;
    localparam int PC_W  = 12;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;
    localparam int NSLOT = 1 << IDX_W;
    localparam int ITOP  = (1 << CNT_W) - 1;

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] pred_pc, upd_pc;
    logic            pred_hit, pred_taken, pred_confident;
    logic            upd_valid, upd_taken;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    loop_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_loop_pred (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_confident(pred_confident),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    // Reference model built from the requirements
    logic                  m_v  [NSLOT];
    logic [PC_W-IDX_W-1:0] m_t  [NSLOT];
    logic                  m_d  [NSLOT];
    logic                  m_k  [NSLOT];
    int                    m_tr [NSLOT];
    int                    m_it [NSLOT];
    int                    m_c  [NSLOT];

    function automatic int ix(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W-1:0]);
    endfunction

    function automatic logic m_hit(input logic [PC_W-1:0] pc);
        return m_v[ix(pc)] && (m_t[ix(pc)] == pc[PC_W-1:IDX_W]);
    endfunction

    function automatic logic m_taken(input logic [PC_W-1:0] pc);
        int i = ix(pc);
        if (!m_hit(pc)) return 1'b0;
        if (m_k[i] && m_it[i] == m_tr[i]) return ~m_d[i];
        return m_d[i];
    endfunction

    function automatic logic m_conf(input logic [PC_W-1:0] pc);
        return m_hit(pc) && (m_c[ix(pc)] == 3);
    endfunction

    task automatic m_update(input logic [PC_W-1:0] pc, input logic o);
        int i = ix(pc);
        if (!m_hit(pc)) begin
            m_v[i] = 1'b1; m_t[i] = pc[PC_W-1:IDX_W]; m_d[i] = o;
            m_k[i] = 1'b0; m_tr[i] = 0; m_it[i] = 1; m_c[i] = 0;
        end else if (o == m_d[i]) begin
            if (m_it[i] == ITOP) m_v[i] = 1'b0;
            else m_it[i]++;
        end else if (m_it[i] == 0) begin
            m_d[i] = o; m_k[i] = 1'b0; m_tr[i] = 0; m_it[i] = 1; m_c[i] = 0;
        end else begin
            if (m_k[i] && m_tr[i] == m_it[i]) m_c[i] = (m_c[i] == 3) ? 3 : m_c[i] + 1;
            else m_c[i] = 0;
            m_tr[i] = m_it[i]; m_k[i] = 1'b1; m_it[i] = 0;
        end
    endtask

    task automatic chk(input string rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", rq, act, exp);
        end
    endtask

    // One cycle: look up pc, optionally update it with outcome o
    task automatic step(input logic [PC_W-1:0] pc, input logic o, input logic u);
        @(negedge clk);
        pred_pc = pc; upd_pc = pc; upd_valid = u; upd_taken = o;
        #1;
        chk("R3 R4 R10 hit", pred_hit, m_hit(pc));
        chk("R3 R4 R8 taken", pred_taken, m_taken(pc));
        chk("R6 R7 confident", pred_confident, m_conf(pc));
        if (u) m_update(pc, o);
    endtask

    task automatic probe(input logic [PC_W-1:0] pc, input logic eh, input logic et,
                         input logic ec, input string rq);
        @(negedge clk);
        pred_pc = pc; upd_valid = 1'b0;
        #1;
        chk({rq, " hit"}, pred_hit, eh);
        chk({rq, " taken"}, pred_taken, et);
        chk({rq, " confident"}, pred_confident, ec);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [PC_W-1:0] lpc [4];
        int              ltrip [4];
        logic            ldir [4];
        int              lph [4];
        int unused_seed;

        unused_seed = $urandom(32'h1F0C_5EED);
        for (int i = 0; i < NSLOT; i++) begin
            m_v[i] = 0; m_t[i] = '0; m_d[i] = 0; m_k[i] = 0;
            m_tr[i] = 0; m_it[i] = 0; m_c[i] = 0;
        end
        rst = 1'b1; upd_valid = 1'b0; upd_taken = 1'b0;
        pred_pc = '0; upd_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        probe(12'h010, 0, 0, 0, "R1");

        // Bottom-of-loop branch, trip 3 taken then one not-taken
        step(12'h010, 1, 1);
        probe(12'h010, 1, 1, 0, "R2 R3");
        step(12'h010, 1, 1); step(12'h010, 1, 1); step(12'h010, 0, 1);
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 3; j++) step(12'h010, 1, 1);
            step(12'h010, 0, 1);
        end
        probe(12'h010, 1, 1, 1, "R5 R7");
        for (int j = 0; j < 3; j++) step(12'h010, 1, 1);
        probe(12'h010, 1, 0, 1, "R4");
        step(12'h010, 0, 1);
        for (int j = 0; j < 5; j++) step(12'h010, 1, 1);
        step(12'h010, 0, 1);
        probe(12'h010, 1, 1, 0, "R6");
        probe(12'h010, 1, 1, 0, "R11");

        // Top-of-loop branch, not-taken dominant
        for (int k = 0; k < 4; k++) begin
            for (int j = 0; j < 3; j++) step(12'h021, 0, 1);
            step(12'h021, 1, 1);
        end
        for (int j = 0; j < 3; j++) step(12'h021, 0, 1);
        probe(12'h021, 1, 1, 1, "R8 exit");
        step(12'h021, 1, 1);
        probe(12'h021, 1, 0, 1, "R8 dominant");

        // Direction flip after two opposite outcomes
        step(12'h032, 1, 1); step(12'h032, 0, 1); step(12'h032, 0, 1);
        probe(12'h032, 1, 0, 0, "R8 flip");

        // Iteration overflow
        for (int j = 0; j < ITOP; j++) step(12'h043, 1, 1);
        probe(12'h043, 1, 1, 0, "R9 at limit");
        step(12'h043, 1, 1);
        probe(12'h043, 0, 0, 0, "R9 dropped");

        // Tag conflict on index 0
        probe(12'h018, 0, 0, 0, "R10 miss");
        step(12'h018, 0, 1);
        probe(12'h010, 0, 0, 0, "R10 evicted");
        probe(12'h018, 1, 0, 0, "R10 owner");

        // Random loop streams with stray branches
        for (int j = 0; j < 4; j++) begin
            lpc[j]   = {PC_W'($urandom) >> IDX_W, IDX_W'(j)};
            ltrip[j] = 1 + int'($urandom % 6);
            ldir[j]  = 1'($urandom);
            lph[j]   = 0;
        end
        for (int n = 0; n < 4000; n++) begin
            int j;
            j = int'($urandom % 4);
            if ($urandom % 20 == 0) begin
                step(PC_W'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                logic o;
                o = (lph[j] < ltrip[j]) ? ldir[j] : ~ldir[j];
                lph[j] = (lph[j] < ltrip[j]) ? lph[j] + 1 : 0;
                step(lpc[j], o, 1'b1);
                if (lph[j] == 0 && $urandom % 16 == 0)
                    ltrip[j] = 1 + int'($urandom % 6);
            end
        end

        summary();
        $finish;
    end
endmodule